// File: doc/BRIEF.md
# Bus Cycle Break Condition Matcher

This block observes every completed bus cycle and raises a sticky break request when the cycle meets a programmed set of conditions. A six-bit control word holds three independent two-bit selectors: one picks the cycle kind (instruction fetch, data access, or both), one picks the direction (read, write, or both), and one picks the operand size. A compare address and a bit mask further qualify the cycle. Any mask bit set to 1 removes the matching address bit from the comparison.

Cycles from the CPU and from the DMA controller are matched in the same way. For data accesses, the size that counts is the operand size stated with the cycle. An instruction fetch always counts as a word access, whatever width the bus physically carried.

Software programs the block through a small synchronous register port with read-back. It clears the request by writing 1 to the flag register.

Top module: `bus_break_matcher`

## Requirements
- R1: After reset, the control word, the compare address and the mask all read 0, `break_req` is 0, and no cycle sets a break until the control word is written.
- R2: The cycle-kind selector sits in control bits [5:4]. 00 never matches, 01 matches only fetch cycles (`cyc_fetch`=1), 10 matches only data cycles, and 11 matches both.
- R3: The direction selector sits in control bits [3:2]. 00 never matches, 01 matches only reads (`cyc_write`=0), 10 matches only writes, and 11 matches both.
- R4: The size selector sits in control bits [1:0]. 00 ignores size, 01 matches `cyc_size`=01 (byte), 10 matches 10 (word), and 11 matches 11 (longword). A data cycle is compared using its own `cyc_size`.
- R5: A fetch cycle is always treated as size 10. It matches size selector 00 or 10 and never 01 or 11, whatever value `cyc_size` carries.
- R6: The address condition holds when `((cyc_addr ^ compare) & ~mask) == 0`.
- R7: A break is recognised only when `cyc_valid` is 1 and all four conditions hold in that cycle. When `cyc_valid` is 0, `break_req` does not change.
- R8: `break_req` rises on the clock edge that samples a matching cycle. It then stays high until a register write to the flag register (select 3) with bit 0 = 1. If a match and a clear occur in the same cycle, the flag stays set.
- R9: Register select 0 holds the control word, 1 the compare address and 2 the mask. Select 3 reads `break_req` in bit 0. `reg_rdata` shows the register picked by `reg_sel` in the same cycle, zero-extended.
- R10: A register write takes effect for bus cycles sampled after the write's clock edge. A cycle sampled on the same edge as the write is matched against the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for write and read |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data |
| cyc_valid | input | 1 | A bus cycle completes this clock |
| cyc_addr | input | ADDR_W | Cycle address |
| cyc_fetch | input | 1 | 1 for instruction fetch, 0 for data access |
| cyc_write | input | 1 | 1 for write, 0 for read |
| cyc_size | input | 2 | Operand size code: 01 byte, 10 word, 11 long |
| break_req | output | 1 | Sticky break request |

## Verification
The bench builds the block with ADDR_W = 8. This makes it affordable to try all 64 control words against every combination of fetch/data, read/write and size code, and to sweep all 256 addresses under several mask patterns. Expected results come from the selector encodings computed in the bench. Directed sequences cover the cases the sweep cannot reach: the same-edge ordering of register writes against cycles, a set and a clear arriving together, and invalid cycles.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    typedef struct packed {
        logic [1:0] kind;
        logic [1:0] dir;
        logic [1:0] size;
    } brk_ctrl_t;

    localparam int CTRL_W = $bits(brk_ctrl_t);

    localparam logic [1:0] SZ_WORD = 2'b10;

    typedef enum logic [1:0] {
        RS_CTRL = 2'd0,
        RS_ADDR = 2'd1,
        RS_MASK = 2'd2,
        RS_FLAG = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/bbm_regs.sv
module bbm_regs
    import bbm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              flag_in,
    output logic [ADDR_W-1:0] rdata,
    output brk_ctrl_t         ctrl,
    output logic [ADDR_W-1:0] cmp_addr,
    output logic [ADDR_W-1:0] cmp_mask,
    output logic              clr_pulse
);

    typedef struct packed {
        brk_ctrl_t         ctrl;
        logic [ADDR_W-1:0] cmp;
        logic [ADDR_W-1:0] msk;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            unique case (reg_sel_e'(sel))
                RS_CTRL: regs_d.ctrl = brk_ctrl_t'(wdata[CTRL_W-1:0]);
                RS_ADDR: regs_d.cmp  = wdata;
                RS_MASK: regs_d.msk  = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        unique case (reg_sel_e'(sel))
            RS_CTRL: rdata = ADDR_W'(regs_q.ctrl);
            RS_ADDR: rdata = regs_q.cmp;
            RS_MASK: rdata = regs_q.msk;
            default: rdata = ADDR_W'(flag_in);
        endcase
    end

    assign ctrl      = regs_q.ctrl;
    assign cmp_addr  = regs_q.cmp;
    assign cmp_mask  = regs_q.msk;
    assign clr_pulse = we && (sel == RS_FLAG) && wdata[0];

    // R9 / R10: a control write is visible from the next cycle onward
    a_r9_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == RS_CTRL) |=> (ctrl == $past(wdata[CTRL_W-1:0])));

    // R9: a mask write lands in the mask register
    a_r9_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == RS_MASK) |=> (cmp_mask == $past(wdata)));

    // R10: without a write, the control word holds
    a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == RS_CTRL) |=> $stable(ctrl));

endmodule

// File: rtl/bbm_match.sv
module bbm_match
    import bbm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_fetch,
    input  logic              is_write,
    input  logic [1:0]        size,
    input  brk_ctrl_t         ctrl,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic [ADDR_W-1:0] cmp_mask,
    output logic              hit
);

    logic       kind_ok, dir_ok, size_ok, addr_ok;
    logic [1:0] eff_size;

    always_comb begin
        kind_ok  = is_fetch ? ctrl.kind[0] : ctrl.kind[1];
        dir_ok   = is_write ? ctrl.dir[1]  : ctrl.dir[0];
        eff_size = is_fetch ? SZ_WORD : size;
        size_ok  = (ctrl.size == 2'b00) || (ctrl.size == eff_size);
        addr_ok  = ((addr ^ cmp_addr) & ~cmp_mask) == '0;
        hit      = valid && kind_ok && dir_ok && size_ok && addr_ok;
    end

endmodule

// File: rtl/bus_break_matcher.sv
module bus_break_matcher
    import bbm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              cyc_valid,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_fetch,
    input  logic              cyc_write,
    input  logic [1:0]        cyc_size,
    output logic              break_req
);

    typedef struct packed {
        logic brk;
    } flag_t;

    brk_ctrl_t         ctrl;
    logic [ADDR_W-1:0] cmp_addr, cmp_mask;
    logic              clr_pulse, hit;
    flag_t             flag_d, flag_q;

    bbm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .flag_in  (flag_q.brk),
        .rdata    (reg_rdata),
        .ctrl     (ctrl),
        .cmp_addr (cmp_addr),
        .cmp_mask (cmp_mask),
        .clr_pulse(clr_pulse)
    );

    bbm_match #(.ADDR_W(ADDR_W)) u_match (
        .valid    (cyc_valid),
        .addr     (cyc_addr),
        .is_fetch (cyc_fetch),
        .is_write (cyc_write),
        .size     (cyc_size),
        .ctrl     (ctrl),
        .cmp_addr (cmp_addr),
        .cmp_mask (cmp_mask),
        .hit      (hit)
    );

    // set has priority over a software clear
    always_comb begin
        flag_d = flag_q;
        if (clr_pulse) flag_d.brk = 1'b0;
        if (hit)       flag_d.brk = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign break_req = flag_q.brk;

    // R2: kind selector 00 blocks every match
    a_r2_kind_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.kind == 2'b00) |-> !hit);

    // R3: direction selector 00 blocks every match
    a_r3_dir_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.dir == 2'b00) |-> !hit);

    // R5: a fetch never matches byte or longword size selectors
    a_r5_fetch_word: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_fetch && ctrl.size[0]) |-> !hit);

    // R6: a hit implies the unmasked address bits agree
    a_r6_addr_match: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (((cyc_addr ^ cmp_addr) & ~cmp_mask) == '0));

    // R7: no hit without a valid cycle
    a_r7_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |-> !hit);

    // R8: a match sets the request, winning over a clear
    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> break_req);

    // R8: the request holds until cleared
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (break_req && !clr_pulse) |=> break_req);

    // R8: a clear without a match drops the request
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && !hit) |=> !break_req);

endmodule

// File: tb/bus_break_matcher_tb.sv
module bus_break_matcher_tb;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          cyc_valid = 1'b0;
    logic [AW-1:0] cyc_addr = '0;
    logic          cyc_fetch = 1'b0;
    logic          cyc_write = 1'b0;
    logic [1:0]    cyc_size = 2'd0;
    logic          break_req;

    int checks = 0;
    int fails  = 0;

    bus_break_matcher #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_valid(cyc_valid),
        .cyc_addr(cyc_addr), .cyc_fetch(cyc_fetch), .cyc_write(cyc_write),
        .cyc_size(cyc_size), .break_req(break_req)
    );

    always #5ns clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1ns;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [AW-1:0] data);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [AW-1:0] data);
        reg_sel = sel;
        #1ns;
        data = reg_rdata;
    endtask

    task automatic bus(input logic [AW-1:0] a, input logic f, input logic w, input logic [1:0] s);
        cyc_valid = 1'b1; cyc_addr = a; cyc_fetch = f; cyc_write = w; cyc_size = s;
        tick();
        cyc_valid = 1'b0;
    endtask

    function automatic logic exp_hit(input logic [5:0] c, input logic f, input logic w, input logic [1:0] s);
        logic kok, dok, sok;
        logic [1:0] eff;
        kok = f ? c[4] : c[5];
        dok = w ? c[3] : c[2];
        eff = f ? 2'b10 : s;
        sok = (c[1:0] == 2'b00) || (c[1:0] == eff);
        return kok && dok && sok;
    endfunction

    initial begin
        #1ms;
        fails++;
        $display("FAIL R7 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [AW-1:0] rv;
        logic [AW-1:0] masks [5];
        masks[0] = 8'h00; masks[1] = 8'h0F; masks[2] = 8'hF0;
        masks[3] = 8'hFF; masks[4] = 8'h81;

        repeat (3) @(posedge clk);
        #1ns rst_n = 1'b1;
        tick();

        // R1: reset state
        rd(2'd0, rv); chk("R1 ctrl", rv, 0);
        rd(2'd1, rv); chk("R1 addr", rv, 0);
        rd(2'd2, rv); chk("R1 mask", rv, 0);
        rd(2'd3, rv); chk("R1 flag readback", rv, 0);
        chk("R1 break_req", break_req, 0);
        bus(8'h00, 1'b1, 1'b0, 2'b10); chk("R1 fetch after reset", break_req, 0);
        bus(8'h00, 1'b0, 1'b1, 2'b11); chk("R1 data after reset", break_req, 0);

        // R9: read-back
        wr(2'd0, 8'h2D); rd(2'd0, rv); chk("R9 ctrl readback", rv, 8'h2D);
        wr(2'd1, 8'h5A); rd(2'd1, rv); chk("R9 addr readback", rv, 8'h5A);
        wr(2'd2, 8'h3C); rd(2'd2, rv); chk("R9 mask readback", rv, 8'h3C);
        wr(2'd0, 8'hC6); rd(2'd0, rv); chk("R9 ctrl upper bits zero", rv, 8'h06);

        // R2 R3 R4 R5: every control word against every cycle attribute combination
        wr(2'd2, 8'hFF);
        for (int c = 0; c < 64; c++) begin
            wr(2'd0, AW'(c));
            for (int f = 0; f < 2; f++)
                for (int w = 0; w < 2; w++)
                    for (int s = 0; s < 4; s++) begin
                        wr(2'd3, 8'h01);
                        bus(AW'(c * 3), f[0], w[0], s[1:0]);
                        chk($sformatf("R2 R3 R4 R5 ctrl=%0h f=%0d w=%0d s=%0d", c, f, w, s),
                            break_req, exp_hit(c[5:0], f[0], w[0], s[1:0]));
                    end
        end

        // R6: masked address compare over all addresses
        wr(2'd0, 8'h3C);
        wr(2'd1, 8'hA5);
        for (int m = 0; m < 5; m++) begin
            wr(2'd2, masks[m]);
            for (int a = 0; a < 256; a++) begin
                wr(2'd3, 8'h01);
                bus(AW'(a), 1'b0, a[0], 2'b01);
                chk($sformatf("R6 mask=%0h addr=%0h", masks[m], a), break_req,
                    ((AW'(a) ^ 8'hA5) & ~masks[m]) == 8'h00);
            end
        end

        // R7: invalid cycle with matching attributes
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'h01);
        cyc_addr = 8'h12; cyc_fetch = 1'b0; cyc_write = 1'b1; cyc_size = 2'b01;
        cyc_valid = 1'b0;
        tick(); tick();
        chk("R7 invalid cycle ignored", break_req, 0);

        // R8: sticky, clear, set wins
        bus(8'h12, 1'b1, 1'b0, 2'b00);
        chk("R8 set on match", break_req, 1);
        tick(); tick(); tick();
        chk("R8 holds while idle", break_req, 1);
        bus(8'h12, 1'b1, 1'b0, 2'b01);
        chk("R8 set again", break_req, 1);
        wr(2'd3, 8'h00);
        chk("R8 write 0 no clear", break_req, 1);
        rd(2'd3, rv); chk("R8 R9 flag readback set", rv, 1);
        wr(2'd3, 8'h01);
        chk("R8 clear", break_req, 0);
        reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = 8'h01;
        bus(8'h40, 1'b0, 1'b0, 2'b11);
        reg_we = 1'b0;
        chk("R8 set wins over clear", break_req, 1);
        wr(2'd3, 8'h01);

        // R10: same-edge write uses old settings
        reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h00;
        bus(8'h40, 1'b0, 1'b0, 2'b11);
        reg_we = 1'b0;
        chk("R10 old ctrl applies on write edge", break_req, 1);
        wr(2'd3, 8'h01);
        bus(8'h40, 1'b0, 1'b0, 2'b11);
        chk("R10 new ctrl disables", break_req, 0);
        reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h3C;
        bus(8'h40, 1'b0, 1'b0, 2'b11);
        reg_we = 1'b0;
        chk("R10 enable not yet active", break_req, 0);
        bus(8'h40, 1'b0, 1'b0, 2'b11);
        chk("R10 enable active next cycle", break_req, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule